// File: doc/BRIEF.md
# Master-Mode Serial Audio Clock Generator

This block produces the bit clock and the frame clock of a serial audio port that drives its own clocks. Both clocks are divided down from the master clock that runs the block, so every output changes only on a master clock edge. Alongside the two clocks it gives single-cycle strobes for each rising and falling bit clock edge and for the start of each frame. A serializer and a deserializer on the same master clock use these strobes in place of sampling the clocks themselves.

The configuration sets the bit clock half-period in master clock cycles, the frame length in bit clocks (64 to 256, even), the frame clock shape and the frame clock polarity. The shape is either a square wave with 50% duty or a pulse one bit clock wide. The polarity sets whether a frame begins on a rising or a falling frame clock edge. Two rate flags mark eight-slot operation and the double frame rate. Eight slots at the double rate cannot be mastered. That combination, and any frame length or divider outside the legal range, holds both clocks idle and raises an error flag.

Top module: `frame_clk_gen`

## Requirements
- R1: While running, `bclk` has a period of 2×`half_div` master clocks. Counting the master clock edges since `en` was first sampled high with a legal configuration as e = 1, 2, …, `bclk` is high exactly when floor(e / `half_div`) is odd.
- R2: `bclk_rise` is high for the one cycle in which `bclk` has just gone from 0 to 1, which is when e mod (2×`half_div`) equals `half_div`. `bclk_fall` is high for the one cycle in which `bclk` has just gone from 1 to 0, which is when e is a nonzero multiple of 2×`half_div`. The two are never high together.
- R3: Falling bit clock edges are numbered as bits 0, 1, … modulo `frame_len`, and the first falling edge after start is bit 0. `frame_start` is high for one cycle, together with `bclk_fall`, on every falling edge that is bit 0.
- R4: With `pulse_mode` = 0 (square), the frame clock is at its active level for bits 0 to `frame_len`/2 − 1 and at its inactive level for the remaining bits. It changes only on falling bit clock edges.
- R5: With `pulse_mode` = 1 (pulse), the frame clock is at its active level during bit 0 only.
- R6: The active level is high when `start_rise` = 1 and low when `start_rise` = 0. Before the first falling edge of a run, and whenever idle, `fclk` is at the inactive level (the inverse of `start_rise`).
- R7: `tdm8` = 1 together with `rate96` = 1 is illegal. Any other combination of these two flags is legal.
- R8: `half_div` = 0 is illegal, and so is a `frame_len` that is odd, below 64 or above 256.
- R9: While `en` is 0, or one cycle after an illegal configuration is sampled, `bclk` is low, all strobes are low and `fclk` is at its inactive level. `cfg_err` is 1 exactly one cycle after `en` = 1 is sampled with an illegal configuration, and 0 otherwise.
- R10: During reset, `bclk`, all strobes and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the clocks |
| half_div | input | DIV_W | Bit clock half-period in master clocks |
| frame_len | input | LEN_W | Bit clocks per frame |
| pulse_mode | input | 1 | 0: square frame clock, 1: one-bit pulse |
| start_rise | input | 1 | 1: frame begins on rising frame clock edge |
| tdm8 | input | 1 | Eight-slot operation requested |
| rate96 | input | 1 | Double frame rate requested |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| bclk_rise | output | 1 | Strobe: bit clock just rose |
| bclk_fall | output | 1 | Strobe: bit clock just fell |
| frame_start | output | 1 | Strobe: bit 0 of a frame just began |
| cfg_err | output | 1 | Illegal configuration with `en` high |

## Verification
All outputs are registered, and each one is due on the master clock edge that completes the divider count. When a configuration is legal, the first edge that samples `en` high counts as e = 1. A toggle is due at every e that is a multiple of `half_div`. Frame clock changes and `frame_start` are due at the falling toggles, and `cfg_err` is due one edge after an illegal setting is sampled. The bench counts edges from the one that samples `en`, samples the outputs on the following falling master clock edge, and compares them with closed-form functions of e.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  localparam int unsigned LEN_MIN = 64;
  localparam int unsigned LEN_MAX = 256;

  typedef enum logic {
    FSHAPE_SQUARE = 1'b0,
    FSHAPE_PULSE  = 1'b1
  } fshape_e;
endpackage

// File: rtl/fcg_cfg_check.sv
module fcg_cfg_check #(
  parameter int DIV_W   = 8,
  parameter int LEN_W   = 9,
  parameter int LEN_MIN = 64,
  parameter int LEN_MAX = 256
) (
  input  logic [DIV_W-1:0] half_div,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             tdm8,
  input  logic             rate96,
  output logic             legal
);
  localparam logic [LEN_W-1:0] LO = LEN_W'(LEN_MIN);
  localparam logic [LEN_W-1:0] HI = LEN_W'(LEN_MAX);

  logic rate_ok, len_ok, div_ok;

  always_comb begin
    rate_ok = !(tdm8 && rate96);
    len_ok  = (frame_len >= LO) && (frame_len <= HI) && !frame_len[0];
    div_ok  = (half_div != '0);
    legal   = rate_ok && len_ok && div_ok;
  end
endmodule

// File: rtl/fcg_bclk_div.sv
module fcg_bclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DIV_W-1:0] half_div,
  output logic             bclk,
  output logic             rise_en,
  output logic             fall_en,
  output logic             fall_tick
);
  logic [DIV_W-1:0] dcnt;
  logic             wrap;

  // wrap marks the edge that ends a half-period
  assign wrap      = go && (dcnt == half_div - DIV_W'(1));
  assign fall_tick = wrap && bclk;

  always_ff @(posedge clk) begin
    if (rst || !go) begin
      dcnt    <= '0;
      bclk    <= 1'b0;
      rise_en <= 1'b0;
      fall_en <= 1'b0;
    end else begin
      rise_en <= wrap && !bclk;
      fall_en <= fall_tick;
      if (wrap) begin
        dcnt <= '0;
        bclk <= ~bclk;
      end else begin
        dcnt <= dcnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/fcg_frame_seq.sv
module fcg_frame_seq #(
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             fall_tick,
  input  logic [LEN_W-1:0] frame_len,
  input  fcg_pkg::fshape_e shape,
  input  logic             act_high,
  output logic             fclk,
  output logic             frame_start
);
  import fcg_pkg::*;

  logic [LEN_W-1:0] bitcnt;
  logic [LEN_W-1:0] nxt;
  logic             act;

  always_comb begin
    nxt = (bitcnt == frame_len - LEN_W'(1)) ? '0 : bitcnt + LEN_W'(1);
    if (shape == FSHAPE_PULSE) act = (nxt == '0);
    else                       act = (nxt < (frame_len >> 1));
  end

  // idle parks the counter on the last bit so the first fall wraps to bit 0
  always_ff @(posedge clk) begin
    if (rst || !go) begin
      bitcnt      <= frame_len - LEN_W'(1);
      fclk        <= ~act_high;
      frame_start <= 1'b0;
    end else begin
      frame_start <= fall_tick && (nxt == '0);
      if (fall_tick) begin
        bitcnt <= nxt;
        fclk   <= act ? act_high : ~act_high;
      end
    end
  end
endmodule

// File: rtl/frame_clk_gen.sv
module frame_clk_gen #(
  parameter int DIV_W   = 8,
  parameter int LEN_W   = 9,
  parameter int LEN_MIN = fcg_pkg::LEN_MIN,
  parameter int LEN_MAX = fcg_pkg::LEN_MAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             pulse_mode,
  input  logic             start_rise,
  input  logic             tdm8,
  input  logic             rate96,
  output logic             bclk,
  output logic             fclk,
  output logic             bclk_rise,
  output logic             bclk_fall,
  output logic             frame_start,
  output logic             cfg_err
);
  import fcg_pkg::*;

  localparam int LEN_CAP = 1 << LEN_W;
  if (LEN_MAX >= LEN_CAP) begin : g_len_w_too_small
    initial $error("LEN_W cannot hold LEN_MAX");
  end

  logic    legal;
  logic    go;
  logic    fall_tick;
  fshape_e shape;

  assign shape = fshape_e'(pulse_mode);
  assign go    = en && legal;

  fcg_cfg_check #(
    .DIV_W(DIV_W), .LEN_W(LEN_W), .LEN_MIN(LEN_MIN), .LEN_MAX(LEN_MAX)
  ) u_cfg (
    .half_div (half_div),
    .frame_len(frame_len),
    .tdm8     (tdm8),
    .rate96   (rate96),
    .legal    (legal)
  );

  fcg_bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .half_div (half_div),
    .bclk     (bclk),
    .rise_en  (bclk_rise),
    .fall_en  (bclk_fall),
    .fall_tick(fall_tick)
  );

  fcg_frame_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .go         (go),
    .fall_tick  (fall_tick),
    .frame_len  (frame_len),
    .shape      (shape),
    .act_high   (start_rise),
    .fclk       (fclk),
    .frame_start(frame_start)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= en && !legal;
  end
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker (
  input logic clk,
  input logic rst,
  input logic start_rise,
  input logic bclk,
  input logic fclk,
  input logic bclk_rise,
  input logic bclk_fall,
  input logic frame_start,
  input logic cfg_err
);
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bclk_rise, bclk_fall}));

  a_r2_rise_matches_edge: assert property (@(posedge clk) disable iff (rst)
    bclk_rise |-> (bclk && !$past(bclk)));

  a_r2_fall_matches_edge: assert property (@(posedge clk) disable iff (rst)
    bclk_fall |-> (!bclk && $past(bclk)));

  a_r3_start_on_fall: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> bclk_fall);

  a_r6_start_active_level: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (fclk == $past(start_rise)));

  a_r4_fclk_steady_on_rise: assert property (@(posedge clk) disable iff (rst)
    bclk_rise |-> $stable(fclk));

  a_r9_err_holds_idle: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!bclk && !bclk_rise && !bclk_fall && !frame_start));
endmodule

bind frame_clk_gen fcg_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_rise (start_rise),
  .bclk       (bclk),
  .fclk       (fclk),
  .bclk_rise  (bclk_rise),
  .bclk_fall  (bclk_fall),
  .frame_start(frame_start),
  .cfg_err    (cfg_err)
);

// File: tb/frame_clk_gen_test.sv
`timescale 1ns/1ps
module frame_clk_gen_test;
  localparam int DIV_W = 8;
  localparam int LEN_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [DIV_W-1:0] half_div = 8'd1;
  logic [LEN_W-1:0] frame_len = 9'd64;
  logic pulse_mode = 1'b0, start_rise = 1'b0, tdm8 = 1'b0, rate96 = 1'b0;
  logic bclk, fclk, bclk_rise, bclk_fall, frame_start, cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  frame_clk_gen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .en(en), .half_div(half_div), .frame_len(frame_len),
    .pulse_mode(pulse_mode), .start_rise(start_rise), .tdm8(tdm8), .rate96(rate96),
    .bclk(bclk), .fclk(fclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .frame_start(frame_start), .cfg_err(cfg_err)
  );

  task automatic chk(string tag, int e, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at e=%0d: actual %0b expected %0b", tag, e, act, exp);
    end
  endtask

  function automatic bit x_bclk(int e, int h);
    return ((e / h) % 2) == 1;
  endfunction
  function automatic bit x_rise(int e, int h);
    return (e % (2*h)) == h;
  endfunction
  function automatic bit x_fall(int e, int h);
    return (e > 0) && ((e % (2*h)) == 0);
  endfunction
  function automatic bit x_fclk(int e, int h, int len, bit p, bit sr);
    int f = e / (2*h);
    int b;
    bit act;
    if (f == 0) return !sr;
    b = (f - 1) % len;
    act = p ? (b == 0) : (b < len/2);
    return act ? sr : !sr;
  endfunction
  function automatic bit x_fs(int e, int h, int len);
    int f = e / (2*h);
    return x_fall(e, h) && (f > 0) && (((f - 1) % len) == 0);
  endfunction

  task automatic run_case(int h, int len, bit p, bit sr, bit t8, bit r96, bit ok, int n);
    @(negedge clk);
    en = 1'b0; half_div = DIV_W'(h); frame_len = LEN_W'(len);
    pulse_mode = p; start_rise = sr; tdm8 = t8; rate96 = r96;
    @(negedge clk);
    @(negedge clk);
    chk("R9 idle bclk", 0, bclk, 1'b0);
    chk("R9 idle strobes", 0, bclk_rise | bclk_fall | frame_start, 1'b0);
    chk("R9 idle no err", 0, cfg_err, 1'b0);
    chk("R6 idle inactive level", 0, fclk, !sr);
    en = 1'b1;
    for (int e = 1; e <= n; e++) begin
      @(negedge clk);
      if (ok) begin
        chk("R1 bclk", e, bclk, x_bclk(e, h));
        chk("R2 rise strobe", e, bclk_rise, x_rise(e, h));
        chk("R2 fall strobe", e, bclk_fall, x_fall(e, h));
        chk("R3 frame_start", e, frame_start, x_fs(e, h, len));
        chk(p ? "R5 pulse fclk" : "R4 square fclk", e, fclk, x_fclk(e, h, len, p, sr));
        chk("R7 legal no err", e, cfg_err, 1'b0);
      end else begin
        chk(t8 && r96 ? "R7 err" : "R8 err", e, cfg_err, 1'b1);
        chk("R9 err bclk idle", e, bclk | bclk_rise | bclk_fall | frame_start, 1'b0);
        chk("R9 err fclk inactive", e, fclk, !sr);
      end
    end
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R9 stop bclk", 0, bclk | bclk_rise | bclk_fall | frame_start, 1'b0);
    chk("R9 stop err clear", 0, cfg_err, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset bclk", 0, bclk, 1'b0);
    chk("R10 reset strobes", 0, bclk_rise | bclk_fall | frame_start, 1'b0);
    chk("R10 reset err", 0, cfg_err, 1'b0);
    rst = 1'b0;
    // directed corners
    run_case(1, 64, 0, 0, 0, 0, 1, 2*1*64*2 + 6);
    run_case(2, 256, 1, 1, 0, 0, 1, 2*2*256 + 12);
    run_case(3, 64, 1, 0, 1, 0, 1, 2*3*64*2 + 4);
    run_case(1, 64, 0, 1, 0, 1, 1, 2*64 + 10);
    run_case(2, 256, 0, 0, 1, 1, 0, 20);
    run_case(0, 64, 0, 1, 0, 0, 0, 20);
    run_case(1, 62, 0, 0, 0, 0, 0, 20);
    run_case(1, 258, 1, 1, 0, 0, 0, 20);
    run_case(1, 65, 0, 0, 0, 0, 0, 20);
    // random legal configurations
    for (int k = 0; k < 8; k++) begin
      int h = 1 + int'($urandom % 4);
      int len = 64 + 2 * int'($urandom % 97);
      bit p = 1'($urandom);
      bit sr = 1'($urandom);
      bit t8 = 1'($urandom);
      run_case(h, len, p, sr, t8, 1'b0, 1, 2*h*len + 4*h + 3);
    end
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule